// File: doc/BRIEF.md
# Operand-Guarded Add/Shift Arithmetic Unit

This block is a two-function arithmetic unit. Each accepted request asks for either a modular sum of two operands or a logical barrel shift of the first operand. Both functional units draw their operands from one shared capture register. That register is never clock-gated and never duplicated, so it can stand in for any shared source of operands.

Activity is suppressed at the unit inputs instead. Each functional unit sits behind its own enable-controlled holding register. A holding register loads from the shared register only when its unit is the one that the in-flight request selects. The other unit keeps seeing the same input values, so no transitions ripple through its logic. A registered select travels with the request, and a multiplexer picks the live unit's result into the output register.

The unit accepts one request per cycle with no stall. Each result appears with a fixed latency, together with a valid strobe. A debug flag reports any cycle in which the inputs of an unselected unit moved.

Top module: `guarded_add_shift_alu`

## Requirements
- R1: While reset is low and after its release, before any request, out_valid is 0, out_result is 0 and leak_flag is 0.
- R2: A request with in_op = 0 yields out_result = (in_a + in_b) mod 2^WIDTH; the carry out of the top bit is dropped.
- R3: A request with in_op = 1 and in_dir = 0 yields in_a shifted left logically by in_b[3:0] places, zero-filled and truncated to WIDTH bits.
- R4: A request with in_op = 1 and in_dir = 1 yields in_a shifted right logically by in_b[3:0] places, zero-filled.
- R5: Every request accepted with in_valid = 1 on a clock edge produces exactly one out_valid pulse with its result on the third following edge, in request order, including back-to-back requests.
- R6: On cycles where out_valid is 0, out_result keeps the last value delivered.
- R7: leak_flag stays 0 throughout: the inputs of the unit not selected by the in-flight request never change.
- R8: When in_valid is 0, in_a, in_b, in_op and in_dir have no effect: no out_valid pulse results and out_result is unchanged.
- R9: For shift requests, the bits of in_b above bit 3 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands and select are captured when high |
| in_op | input | 1 | Operation select: 0 add, 1 shift |
| in_dir | input | 1 | Shift direction: 0 left logical, 1 right logical |
| in_a | input | WIDTH | First operand; the shift data for shift requests |
| in_b | input | WIDTH | Second operand; its low bits give the shift amount |
| out_valid | output | 1 | High for one cycle with each result |
| out_result | output | WIDTH | Registered result |
| leak_flag | output | 1 | Debug: an unselected unit's inputs changed this cycle |

## Verification
A wrong guard enable first shows up on leak_flag. The flag rises in the cycle right after the stray load, and the results can still look correct. A select that has drifted out of step with the operands shows up as a wrong out_result on the very next valid output, because the multiplexer then picks a stale unit. A broken shift stage or adder is exposed by the exhaustive amount and direction sweep and by the carry-wrap operand pairs. Any slip in the valid pipeline makes the pulse arrive a cycle early or late against the three-edge latency, or disturb the held result during idle gaps.

// File: rtl/alu_guard_pkg.sv
// Package: shared encodings for the guarded add/shift unit.
// Assumes a single select bit and a single direction bit.
package alu_guard_pkg;
    typedef enum logic {
        OP_ADD   = 1'b0,
        OP_SHIFT = 1'b1
    } alu_op_e;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    // Shift-amount field width for a given data width
    function automatic int amt_bits(input int width);
        return $clog2(width);
    endfunction
endpackage

// File: rtl/guard_hold.sv
// Module: guard_hold
// Enable-controlled holding register in front of one functional unit.
// It loads only while its unit is selected and otherwise keeps its value,
// so the unit behind it sees no input transitions.
// Assumes en is already qualified with the request valid.
module guard_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on enable, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end

    // R7: with the enable low, the guarded value must not move
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
endmodule

// File: rtl/add_unit.sv
// Module: add_unit
// Combinational modular adder; the carry out is discarded.
// Assumes operands arrive from a guard register.
module add_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);
    // Sum wraps modulo 2^W
    always_comb sum = op_a + op_b;
endmodule

// File: rtl/barrel_shift_unit.sv
// Module: barrel_shift_unit
// Logarithmic barrel shifter, logical left or right, zero fill.
// One stage per shift-amount bit, each stage moves by a power of two.
// clk and rst_n serve only the local check.
module barrel_shift_unit #(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  data,
    input  logic [AW-1:0] amt,
    input  logic          dir,
    output logic [W-1:0]  result
);
    import alu_guard_pkg::*;

    logic [W-1:0] stage [0:AW];

    assign stage[0] = data;

    for (genvar i = 0; i < AW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        // Stage i: conditional move by 2^i
        always_comb begin
            if (!amt[i])               stage[i+1] = stage[i];
            else if (dir == DIR_RIGHT) stage[i+1] = stage[i] >> STEP;
            else                       stage[i+1] = stage[i] << STEP;
        end
    end

    assign result = stage[AW];

    // R3/R4: a zero amount must pass data through in either direction
    assert_zero_amt_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (amt == '0) |-> (result == data));
endmodule

// File: rtl/activity_monitor.sv
// Module: activity_monitor
// Debug observer: raises leak_flag when the inputs of a unit changed
// although the in-flight request did not select that unit.
// Assumes the *_sel inputs describe the load made at the last edge.
module activity_monitor #(
    parameter int ADD_W = 32,
    parameter int SHF_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_sel,
    input  logic             shf_sel,
    input  logic [ADD_W-1:0] add_bus,
    input  logic [SHF_W-1:0] shf_bus,
    output logic             leak_flag
);
    logic [ADD_W-1:0] add_prev;
    logic [SHF_W-1:0] shf_prev;

    // Remember last cycle's unit inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            add_prev <= '0;
            shf_prev <= '0;
        end else begin
            add_prev <= add_bus;
            shf_prev <= shf_bus;
        end
    end

    // Flag a change on a unit that was not selected
    always_comb begin
        leak_flag = ((add_bus != add_prev) && !add_sel)
                 || ((shf_bus != shf_prev) && !shf_sel);
    end

    // R7: isolation of the idle unit must never break
    assert_no_leak_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !leak_flag);
endmodule

// File: rtl/guarded_add_shift_alu.sv
// Module: guarded_add_shift_alu (top)
// Pipeline: shared capture register -> per-unit guard registers ->
// adder / barrel shifter -> select mux -> output register.
// Latency: the result is valid on the third edge after acceptance.
// Assumes one request per cycle at most and no backpressure.
module guarded_add_shift_alu #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic             in_dir,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_result,
    output logic             leak_flag
);
    import alu_guard_pkg::*;

    localparam int AW    = amt_bits(WIDTH);
    localparam int ADD_W = 2 * WIDTH;
    localparam int SHF_W = WIDTH + AW + 1;

    // Shared capture stage
    logic             cap_valid;
    alu_op_e          cap_op;
    logic             cap_dir;
    logic [WIDTH-1:0] cap_a, cap_b;

    // Guard stage
    logic             grd_valid;
    alu_op_e          grd_op;
    logic             add_en, shf_en;
    logic [ADD_W-1:0] add_q;
    logic [SHF_W-1:0] shf_q;

    // Unit results
    logic [WIDTH-1:0] sum_res, shf_res, mux_res;

    // Capture operands and select into the one shared register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_op    <= OP_ADD;
            cap_dir   <= 1'b0;
            cap_a     <= '0;
            cap_b     <= '0;
        end else begin
            cap_valid <= in_valid;
            if (in_valid) begin
                cap_op  <= alu_op_e'(in_op);
                cap_dir <= in_dir;
                cap_a   <= in_a;
                cap_b   <= in_b;
            end
        end
    end

    // Guard enables: only the selected unit loads
    always_comb begin
        add_en = cap_valid && (cap_op == OP_ADD);
        shf_en = cap_valid && (cap_op == OP_SHIFT);
    end

    guard_hold #(.W(ADD_W)) u_add_guard (
        .clk(clk), .rst_n(rst_n), .en(add_en),
        .d({cap_a, cap_b}), .q(add_q)
    );

    guard_hold #(.W(SHF_W)) u_shf_guard (
        .clk(clk), .rst_n(rst_n), .en(shf_en),
        .d({cap_dir, cap_b[AW-1:0], cap_a}), .q(shf_q)
    );

    // Select travels alongside the guard registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grd_valid <= 1'b0;
            grd_op    <= OP_ADD;
        end else begin
            grd_valid <= cap_valid;
            if (cap_valid) grd_op <= cap_op;
        end
    end

    add_unit #(.W(WIDTH)) u_add (
        .op_a(add_q[ADD_W-1:WIDTH]),
        .op_b(add_q[WIDTH-1:0]),
        .sum(sum_res)
    );

    barrel_shift_unit #(.W(WIDTH), .AW(AW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .data(shf_q[WIDTH-1:0]),
        .amt(shf_q[WIDTH+AW-1:WIDTH]),
        .dir(shf_q[SHF_W-1]),
        .result(shf_res)
    );

    // Output multiplexer picks the live unit
    always_comb mux_res = (grd_op == OP_SHIFT) ? shf_res : sum_res;

    // Output register: updates only with a valid result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= grd_valid;
            if (grd_valid) out_result <= mux_res;
        end
    end

    activity_monitor #(.ADD_W(ADD_W), .SHF_W(SHF_W)) u_mon (
        .clk(clk), .rst_n(rst_n),
        .add_sel(grd_valid && (grd_op == OP_ADD)),
        .shf_sel(grd_valid && (grd_op == OP_SHIFT)),
        .add_bus(add_q),
        .shf_bus(shf_q),
        .leak_flag(leak_flag)
    );

    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_result == '0)));

    // R5: a request in the capture stage reaches the guard stage next cycle
    assert_valid_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> grd_valid);

    // R5: a request in the guard stage leaves as an output next cycle
    assert_valid_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grd_valid |=> out_valid);

    // R6: no valid result means the output holds
    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result));

    // R8: an idle input cycle produces nothing in the capture stage
    assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !cap_valid);

    // R7: at most one guard register loads per cycle
    assert_one_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({add_en, shf_en}));
endmodule

// File: tb/tb_guarded_add_shift_alu.sv
// Bench: sweeps of add and shift requests, with idle gaps,
// against arithmetic computed here.
module tb_guarded_add_shift_alu;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_op = 1'b0;
    logic         in_dir = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_result;
    logic         leak_flag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [W-1:0] exp_res [0:255];
    int           exp_cyc [0:255];
    int           exp_req [0:255];
    logic [7:0]   wr_ptr = '0;
    logic [7:0]   rd_ptr = '0;
    logic [W-1:0] last_res = '0;
    logic [15:0]  lfsr = 16'hACE1;

    guarded_add_shift_alu #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dir(in_dir), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result), .leak_flag(leak_flag)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Outputs are sampled at the negative edge
    task automatic sample();
        if (out_valid) begin
            if (rd_ptr == wr_ptr) begin
                check(1'b0, "R5 unexpected valid", 1, 0);
            end else begin
                check(out_result == exp_res[rd_ptr],
                      $sformatf("R%0d result", exp_req[rd_ptr]),
                      int'(out_result), int'(exp_res[rd_ptr]));
                check(cyc == exp_cyc[rd_ptr], "R5 latency", cyc, exp_cyc[rd_ptr]);
                rd_ptr++;
            end
            last_res = out_result;
        end else begin
            // R6 / R8: idle output holds its value
            check(out_result == last_res, "R6 hold", int'(out_result), int'(last_res));
        end
        // R7: isolation flag never rises
        check(!leak_flag, "R7 leak", int'(leak_flag), 0);
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        sample();
    endtask

    task automatic issue(input bit op, input bit dir, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        logic [W-1:0] e;
        int r;
        if (!op) begin
            e = a + b;            // R2: modular sum
            r = 2;
        end else if (!dir) begin
            e = a << b[3:0];      // R3: left logical
            r = 3;
        end else begin
            e = a >> b[3:0];      // R4: right logical
            r = 4;
        end
        in_valid = 1'b1; in_op = op; in_dir = dir; in_a = a; in_b = b;
        exp_res[wr_ptr] = e;
        exp_cyc[wr_ptr] = cyc + 3;
        exp_req[wr_ptr] = r;
        wr_ptr++;
        tick();
    endtask

    // R8: garbage on the data inputs while in_valid is low
    task automatic idle();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        in_valid = 1'b0; in_op = lfsr[0]; in_dir = lfsr[1];
        in_a = lfsr; in_b = ~lfsr;
        tick();
    endtask

    initial begin
        logic [W-1:0] pat [0:7];
        pat[0] = 16'h0001; pat[1] = 16'h8000; pat[2] = 16'hFFFF; pat[3] = 16'hA5C3;
        pat[4] = 16'h1234; pat[5] = 16'h0F0F; pat[6] = 16'h7FFE; pat[7] = 16'h0000;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!out_valid && out_result == '0 && !leak_flag, "R1 in reset",
              int'({out_valid, leak_flag}), 0);
        rst_n = 1'b1;
        tick();
        check(!out_valid && out_result == '0 && !leak_flag, "R1 after release",
              int'(out_result), 0);

        // R3/R4/R9: every amount and direction, with junk in b's upper bits
        for (int p = 0; p < 8; p++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 16; s++)
                    issue(1'b1, d[0], pat[p], {pat[(p + s) % 8][15:4], s[3:0]});

        // R2: add grid including carry wrap
        for (int i = 0; i < 40; i++)
            for (int j = 0; j < 40; j++)
                issue(1'b0, 1'b0, W'(i * 1693 + 16'hF000), W'(j * 2371 + i));
        issue(1'b0, 1'b0, 16'hFFFF, 16'h0001);
        issue(1'b0, 1'b0, 16'h8000, 16'h8000);

        // R5/R7/R8: mixed interleave with gaps
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2] && lfsr[5]) idle();
            else issue(lfsr[0], lfsr[1], lfsr ^ 16'h3C5A, {lfsr[7:0], lfsr[15:8]});
        end

        // Drain and confirm every request produced one result (R5)
        repeat (6) idle();
        check(rd_ptr == wr_ptr, "R5 all delivered", int'(rd_ptr), int'(wr_ptr));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule